// File: doc/BRIEF.md
# LPI Table Base Register Unit

This unit holds the two 64-bit base registers that tell an interrupt redistributor where its LPI property table and its LPI pending table sit in memory. Software reaches them through a simple register port, either with one 64-bit access or with a 32-bit access to one half. Each write is merged into the value already held, then cleaned before it is stored. Cleaning moves the memory-attribute fields to encodings the memory system accepts and clears the reserved bits. As a result, a stored base value is always well formed.

A control register holds the LPI enable bit. While that bit is set, both base registers are frozen. The enable bit can only change when the LPI capability input is high. A 0-to-1 change of the enable bit produces a one-cycle pulse, so that downstream logic can start loading the tables.

Register map (byte offsets): control at 0x00, property base at 0x08, pending base at 0x10. Any other offset reads as zero and ignores writes.

Top module: `lpi_base_regs`

## Requirements
- R1: A write with `wide_i`=1 to a base register replaces all 64 bits with the cleaned `wdata_i`. The write takes effect at the next clock edge.
- R2: A write with `wide_i`=0 updates one half of the register, taken from `wdata_i[31:0]`. `addr_i[2]`=1 selects bits 63:32 and `addr_i[2]`=0 selects bits 31:0. The other half keeps its value.
- R3: Reads are combinational. `rdata_o` is the selected 64-bit value shifted right by 8×`addr_i[2:0]` bits. When `wide_i`=0, `rdata_o` is then cut to its low 32 bits. The control register reads as the enable bit in bit 0, with all other bits zero.
- R4: The shareability field sits at bits 11:10 and is encoded 0 = none, 1 = inner, 2 = outer. A written value of 2 is stored as 1. The values 0, 1 and 3 are stored unchanged.
- R5: The inner-cacheability field sits at bits 9:7. A written value of 0 (device) or 1 (non-cacheable) is stored as 3 (read-allocate write-back). All other values are stored unchanged.
- R6: The outer-cacheability field sits at bits 58:56. A written value of 0 (same as inner) or 1 (non-cacheable) is stored unchanged. Any other value is stored as 1.
- R7: In the property base register, bits 63:59, 55:48 and 6:5 are zero after any write.
- R8: In the pending base register, bits 63, 61:59, 55:48, 15:12 and 6:0 are zero after any write.
- R9: While the enable bit is 1, writes to either base register leave it unchanged.
- R10: A write to the control register loads `wdata_i[0]` into the enable bit only when `lpi_cap_i` is 1. With `lpi_cap_i`=0 the enable bit keeps its value.
- R11: `lpi_on_o` is high for exactly the one cycle after the clock edge at which the enable bit goes from 0 to 1.
- R12: After reset, both base registers read as zero, the enable bit is 0 and `lpi_on_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lpi_cap_i | input | 1 | LPI support is configured |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| addr_i | input | 5 | Byte offset of the access |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data (combinational) |
| lpi_en_o | output | 1 | Current LPI enable bit |
| lpi_on_o | output | 1 | One-cycle pulse when LPIs become enabled |

## Verification
The assertions check the following on every cycle:
- the stored reserved bits are zero;
- the shareability field never holds the outer code, and the outer-cacheability field only ever holds codes 0 or 1;
- a locked or incapable write leaves its target unchanged;
- a 32-bit write keeps the other half;
- the enable pulse coincides with a rise of the enable bit.

The exact remapping of every attribute code, the byte-offset extraction on reads and the reset values show only in the bench's scenarios. Those scenarios sweep all field combinations in both registers and compare the read-back values against an arithmetic model.

// File: rtl/lpi_base_pkg.sv
package lpi_base_pkg;
  localparam int unsigned REG_W  = 64;
  localparam int unsigned HALF_W = REG_W / 2;
  localparam int unsigned SH_LO  = 10;
  localparam int unsigned IC_LO  = 7;
  localparam int unsigned OC_LO  = 56;

  localparam logic [1:0] SH_INNER = 2'd1;
  localparam logic [1:0] SH_OUTER = 2'd2;
  localparam logic [2:0] C_DEV    = 3'd0;
  localparam logic [2:0] C_SAME   = 3'd0;
  localparam logic [2:0] C_NC     = 3'd1;
  localparam logic [2:0] C_RAWB   = 3'd3;

  localparam logic [REG_W-1:0] PROP_RES0 = 64'hF8FF_0000_0000_0060;
  localparam logic [REG_W-1:0] PEND_RES0 = 64'hB8FF_0000_0000_F07F;

  typedef enum logic [1:0] {RGN_CTRL, RGN_PROP, RGN_PEND, RGN_NONE} rgn_e;

  function automatic logic [1:0] fix_share(logic [1:0] f);
    return (f == SH_OUTER) ? SH_INNER : f;
  endfunction

  function automatic logic [2:0] fix_inner(logic [2:0] f);
    return (f == C_DEV || f == C_NC) ? C_RAWB : f;
  endfunction

  function automatic logic [2:0] fix_outer(logic [2:0] f);
    return (f == C_SAME || f == C_NC) ? f : C_NC;
  endfunction
endpackage

// File: rtl/lpi_attr_clean.sv
module lpi_attr_clean
  import lpi_base_pkg::*;
#(
  parameter logic [REG_W-1:0] RES0 = '0
) (
  input  logic [REG_W-1:0] raw_i,
  output logic [REG_W-1:0] clean_o
);
  logic [REG_W-1:0] fixed;

  always_comb begin
    fixed = raw_i;
    fixed[SH_LO +: 2] = fix_share(raw_i[SH_LO +: 2]);
    fixed[IC_LO +: 3] = fix_inner(raw_i[IC_LO +: 3]);
    fixed[OC_LO +: 3] = fix_outer(raw_i[OC_LO +: 3]);
    clean_o = fixed & ~RES0;
  end
endmodule

// File: rtl/lpi_half_merge.sv
module lpi_half_merge
  import lpi_base_pkg::*;
(
  input  logic [REG_W-1:0] cur_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             wide_i,
  input  logic             hi_i,
  output logic [REG_W-1:0] merged_o
);
  always_comb begin
    if (wide_i)    merged_o = wdata_i;
    else if (hi_i) merged_o = {wdata_i[HALF_W-1:0], cur_i[HALF_W-1:0]};
    else           merged_o = {cur_i[REG_W-1:HALF_W], wdata_i[HALF_W-1:0]};
  end
endmodule

// File: rtl/lpi_ctrl_reg.sv
module lpi_ctrl_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic cap_i,
  input  logic wbit_i,
  output logic en_o,
  output logic on_o
);
  logic en_q, on_q, en_d;

  always_comb begin
    en_d = en_q;
    if (wr_i && cap_i) en_d = wbit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      on_q <= 1'b0;
    end else begin
      en_q <= en_d;
      on_q <= !en_q && en_d;
    end
  end

  assign en_o = en_q;
  assign on_o = on_q;
endmodule

// File: rtl/lpi_base_regs.sv
module lpi_base_regs
  import lpi_base_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lpi_cap_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              lpi_en_o,
  output logic              lpi_on_o
);
  localparam int unsigned NREG = 2;

  rgn_e             rgn;
  logic [2:0]       byte_off;
  logic             wr;
  logic [REG_W-1:0] base_q [NREG];
  logic             en_q;

  assign rgn      = (addr_i[ADDR_W-1:5] != '0) ? RGN_NONE : rgn_e'(addr_i[4:3]);
  assign byte_off = addr_i[2:0];
  assign wr       = req_i && we_i;

  lpi_ctrl_reg u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (wr && rgn == RGN_CTRL),
    .cap_i (lpi_cap_i),
    .wbit_i(wdata_i[0]),
    .en_o  (en_q),
    .on_o  (lpi_on_o)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_base
    localparam logic [REG_W-1:0] MASK = (g == 0) ? PROP_RES0 : PEND_RES0;
    localparam rgn_e MY_RGN = (g == 0) ? RGN_PROP : RGN_PEND;
    logic [REG_W-1:0] merged, cleaned;
    logic             hit;

    assign hit = wr && (rgn == MY_RGN) && !en_q;

    lpi_half_merge u_merge (
      .cur_i   (base_q[g]),
      .wdata_i (wdata_i),
      .wide_i  (wide_i),
      .hi_i    (addr_i[2]),
      .merged_o(merged)
    );

    lpi_attr_clean #(.RES0(MASK)) u_clean (
      .raw_i  (merged),
      .clean_o(cleaned)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  base_q[g] <= '0;
      else if (hit) base_q[g] <= cleaned;
    end
  end

  logic [REG_W-1:0] sel, shifted;

  always_comb begin
    case (rgn)
      RGN_CTRL: sel = {{(REG_W-1){1'b0}}, en_q};
      RGN_PROP: sel = base_q[0];
      RGN_PEND: sel = base_q[1];
      default:  sel = '0;
    endcase
    shifted = sel >> {byte_off, 3'b000};
    rdata_o = wide_i ? shifted : {{HALF_W{1'b0}}, shifted[HALF_W-1:0]};
  end

  assign lpi_en_o = en_q;
endmodule

// File: rtl/lpi_base_regs_chk.sv
module lpi_base_regs_chk
  import lpi_base_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lpi_cap_i,
  input logic             req_i,
  input logic             we_i,
  input logic             wide_i,
  input logic [4:0]       addr_i,
  input logic [REG_W-1:0] prop_q,
  input logic [REG_W-1:0] pend_q,
  input logic             lpi_en_o,
  input logic             lpi_on_o
);
  logic wr_base, wr_ctrl;
  assign wr_base = req_i && we_i && (addr_i[4:3] == 2'd1 || addr_i[4:3] == 2'd2);
  assign wr_ctrl = req_i && we_i && addr_i[4:3] == 2'd0;

  // R7
  prop_res0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prop_q & PROP_RES0) == '0);

  // R8
  pend_res0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & PEND_RES0) == '0);

  // R4
  no_outer_share_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prop_q[SH_LO +: 2] != SH_OUTER && pend_q[SH_LO +: 2] != SH_OUTER);

  // R6
  outer_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prop_q[OC_LO +: 3] <= 3'd1 && pend_q[OC_LO +: 3] <= 3'd1);

  // R9
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_base && lpi_en_o) |=> ($stable(prop_q) && $stable(pend_q)));

  // R10
  no_cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !lpi_cap_i) |=> $stable(lpi_en_o));

  // R11
  on_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpi_on_o |-> ($rose(lpi_en_o) || $past(!lpi_en_o)) && lpi_en_o);

  // R11
  on_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpi_on_o |=> !lpi_on_o);

  // R2
  lo_keeps_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_base && !wide_i && !addr_i[2]) |=>
      (prop_q[63:32] == $past(prop_q[63:32]) && pend_q[63:32] == $past(pend_q[63:32])));
endmodule

bind lpi_base_regs lpi_base_regs_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .lpi_cap_i(lpi_cap_i),
  .req_i    (req_i),
  .we_i     (we_i),
  .wide_i   (wide_i),
  .addr_i   (addr_i[4:0]),
  .prop_q   (base_q[0]),
  .pend_q   (base_q[1]),
  .lpi_en_o (lpi_en_o),
  .lpi_on_o (lpi_on_o)
);

// File: tb/lpi_base_regs_tb_top.sv
module lpi_base_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lpi_cap_i = 1'b1;
  logic        req_i = 1'b0, we_i = 1'b0, wide_i = 1'b1;
  logic [4:0]  addr_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic        lpi_en_o, lpi_on_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  lpi_base_regs dut_i (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic w, logic [63:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; wide_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [4:0] a, logic w, output logic [63:0] d);
    wide_i = w; addr_i = a;
    #1 d = rdata_o;
  endtask

  function automatic logic [63:0] model(logic [63:0] v, bit pend);
    logic [63:0] r = v;
    if (r[11:10] == 2) r[11:10] = 1;
    if (r[9:7] < 2) r[9:7] = 3;
    if (r[58:56] > 1) r[58:56] = 1;
    if (!pend) begin
      r[63:59] = 0; r[55:48] = 0; r[6:5] = 0;
    end else begin
      r[63] = 0; r[61:59] = 0; r[55:48] = 0; r[15:12] = 0; r[6:0] = 0;
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, v, e;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R12
    rd(5'h08, 1, d); check("R12 prop reset", d, 0);
    rd(5'h10, 1, d); check("R12 pend reset", d, 0);
    rd(5'h00, 1, d); check("R12 ctrl reset", d, 0);
    check("R12 pulse reset", {63'b0, lpi_on_o}, 0);

    // R1 R4 R5 R6 R7 R8: full attribute sweep on both registers
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 256; i++) begin
        v = {32'hA5C3_96E1 ^ i, 32'h1357_9BDF ^ (i << 5)};
        v[11:10] = i[7:6]; v[9:7] = i[5:3]; v[58:56] = i[2:0];
        wr(r ? 5'h10 : 5'h08, 1, v);
        rd(r ? 5'h10 : 5'h08, 1, d);
        check("R1 R4 R5 R6 sweep", d, model(v, r[0]));
      end
      wr(r ? 5'h10 : 5'h08, 1, '1);
      rd(r ? 5'h10 : 5'h08, 1, d);
      check(r ? "R8 reserved" : "R7 reserved", d, model('1, r[0]));
    end

    // R2 half writes
    wr(5'h08, 1, 64'h0000_0000_0000_0180);
    wr(5'h0C, 0, 64'h0000_0000_0102_0304);
    rd(5'h08, 1, d);
    check("R2 hi half", d, model(64'h0102_0304_0000_0180, 0));
    wr(5'h08, 0, 64'hFFFF_FFFF_0000_0B80);
    rd(5'h08, 1, d);
    check("R2 lo half", d, model(64'h0102_0304_0000_0B80, 0));

    // R3 read extraction
    e = model(64'h0102_0304_0000_0B80, 0);
    rd(5'h0C, 0, d); check("R3 upper word", d, {32'b0, e[63:32]});
    rd(5'h08, 0, d); check("R3 lower word", d, {32'b0, e[31:0]});
    rd(5'h0A, 0, d); check("R3 offset 2", d, {32'b0, e[47:16]});
    rd(5'h18, 1, d); check("R3 unmapped", d, 0);

    // R10 no capability
    lpi_cap_i = 0;
    wr(5'h00, 0, 64'h1);
    rd(5'h00, 0, d); check("R10 no cap", d, 0);
    check("R11 no pulse without cap", {63'b0, lpi_on_o}, 0);
    lpi_cap_i = 1;

    // R11 pulse and R9 lock
    wr(5'h00, 0, 64'h1);
    check("R11 pulse high", {63'b0, lpi_on_o}, 1);
    @(negedge clk_i);
    check("R11 pulse gone", {63'b0, lpi_on_o}, 0);
    rd(5'h00, 0, d); check("R10 enable set", d, 1);
    wr(5'h00, 0, 64'h1);
    check("R11 no repeat pulse", {63'b0, lpi_on_o}, 0);
    wr(5'h08, 1, 64'h0000_0000_1234_0000);
    rd(5'h08, 1, d); check("R9 prop locked", d, e);
    wr(5'h14, 0, 64'h0000_0000_0003_0000);
    rd(5'h10, 1, d); check("R9 pend locked", d, model('1, 1));
    lpi_cap_i = 0;
    wr(5'h00, 0, 64'h0);
    rd(5'h00, 0, d); check("R10 clear blocked", d, 1);
    lpi_cap_i = 1;
    wr(5'h00, 0, 64'h0);
    rd(5'h00, 0, d); check("R10 cleared", d, 0);
    wr(5'h08, 1, 64'h0000_0000_1234_0000);
    rd(5'h08, 1, d); check("R9 unlocked write", d, model(64'h0000_0000_1234_0000, 0));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule